// File: doc/BRIEF.md
# Dual-Protocol Configuration Register Port

This block is a slave control port that fills a small bank of 8-bit configuration registers from either a two-wire bus in the I2C style or a three-wire bus in the SPI style. The two buses share three pins: a serial clock, a serial data line and a select line. The select line carries the low device-address bit on the two-wire bus and the active-low chip select on the three-wire bus. A mode input is captured in the first clock cycle after reset and fixes the bus until the next reset. All pins are oversampled by the system clock through synchronizers.

Every transfer goes through a shared 7-bit register pointer. A pointer byte loads that pointer, and its top bit enables auto-increment. Data bytes are written at the pointer. On the two-wire bus the master can also read registers back: the master first sends a write that holds only the pointer byte, then starts a read. The three-wire bus accepts writes only. The register contents are always present on a flat parallel output, which the rest of the chip decodes.

Top module: `dual_ctrl_port`

## Requirements
- R1: `mode_i` is sampled once, in the first clock cycle after `rst_ni` is released (0 selects two-wire, 1 selects three-wire). Later changes of `mode_i` have no effect until the next reset.
- R2: On the two-wire bus the device address is the 7-bit value {6'b001000, `sel_i`}, followed by the R/W bit (1 = read). An address byte that does not match gets no ACK, and the rest of that transfer changes no register.
- R3: On the two-wire bus the slave pulls the data line low for the ninth clock after every byte it accepts, meaning a matching address byte, a pointer byte or a data byte.
- R4: The pointer byte holds the auto-increment enable in bit 7 and the register address in bits 6:0. With the enable at 0, all following data bytes land on the same address.
- R5: With the enable at 1, the pointer advances by one after each data byte, so successive bytes fill successive addresses.
- R6: A data byte aimed at an address of 5 or more changes no register. The pointer still advances when auto-increment is enabled.
- R7: A two-wire read returns the register at the pointer, MSB first, and returns 00h for addresses of 5 or more. With auto-increment enabled the pointer advances after each byte read. A master NACK ends the read.
- R8: A three-wire frame starts when `sel_i` goes low and ends when it goes high. The frame carries a chip byte 20h, then the pointer byte, then data bytes, each MSB first and sampled on the rising serial clock.
- R9: A three-wire frame whose chip byte is not 20h is ignored, including a byte that requests a read. In three-wire mode `sdat_oe_o` is never asserted.
- R10: After reset all registers read 00h, the pointer is 0 with auto-increment disabled, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Bus select, captured after reset: 0 two-wire, 1 three-wire |
| sclk_i | input | 1 | Serial clock (two-wire SCL or three-wire clock) |
| sdat_i | input | 1 | Serial data as seen on the wire |
| sel_i | input | 1 | Two-wire address LSB, or three-wire active-low chip select |
| sdat_oe_o | output | 1 | Pull data line low when 1 (open-drain) |
| regs_o | output | NUM_REGS*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
Two things can happen in the same cycle: a data byte is committed at the pointer, and the pointer moves on to the next address. The same is true on the read path, where the pointer advances while the next outgoing byte is taken from the register bank. The bench provokes both by sending multi-byte bursts with auto-increment on and off, including a burst that runs from address 4 past the end of the bank, and reads back across that boundary. A behavioural model of the bank and pointer is compared with `regs_o` on every settled clock, and each read byte and each ACK bit is checked against the model.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int DW    = 8;
  localparam int PTR_W = 7;

  typedef struct packed {
    logic          ptr_we;
    logic          dat_we;
    logic          rd_adv;
    logic [DW-1:0] data;
  } cp_req_t;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_PTR, I_WDATA, I_RSTART, I_RDATA
  } i2c_st_e;
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cp_regfile.sv
module cp_regfile import cp_pkg::*; #(
  parameter int NUM_REGS = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  cp_req_t                req_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS-1);

  logic [PTR_W-1:0] ptr_q;
  logic             incr_q;
  logic [DW-1:0]    mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else if (req_i.ptr_we) begin
      incr_q <= req_i.data[7];
      ptr_q  <= req_i.data[PTR_W-1:0];
    end else if ((req_i.dat_we || req_i.rd_adv) && incr_q) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (req_i.dat_we && ptr_q == PTR_W'(g)) mem_q[g] <= req_i.data;
    end
    assign regs_o[g*DW +: DW] = mem_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_q == PTR_W'(i)) rd_data_o = mem_q[i];
  end

  p_incr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.dat_we && !req_i.ptr_we && incr_q) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_hold_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.dat_we && !req_i.ptr_we && !incr_q) |=> $stable(ptr_q));
  p_oob_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.dat_we && ptr_q > LAST) |=> $stable(regs_o));
endmodule

// File: rtl/cp_i2c_fsm.sv
module cp_i2c_fsm import cp_pkg::*; (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic [6:0]   dev_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output cp_req_t      req_o,
  output logic         sda_oe_o
);
  i2c_st_e       st_q;
  logic          scl_q, sda_q, ack_ph_q, ack_drv_q;
  logic [3:0]    bit_cnt_q;
  logic [DW-1:0] sh_q, tx_q;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= I_IDLE; bit_cnt_q <= '0; ack_ph_q <= 1'b0; ack_drv_q <= 1'b0;
      sh_q <= '0; tx_q <= '0; req_o <= '0;
    end else begin
      req_o <= '0;
      if (!en_i || stop_ev) begin
        st_q <= I_IDLE; ack_ph_q <= 1'b0; ack_drv_q <= 1'b0;
      end else if (start_ev) begin
        st_q <= I_ADDR; bit_cnt_q <= '0; ack_ph_q <= 1'b0; ack_drv_q <= 1'b0;
      end else if (st_q != I_IDLE) begin
        if (scl_rise) begin
          if (!ack_ph_q) begin
            sh_q      <= {sh_q[DW-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (st_q == I_RDATA) begin
            req_o.rd_adv <= 1'b1;
            if (sda_i) st_q <= I_IDLE;  // master NACK
          end
        end
        if (scl_fall) begin
          if (ack_ph_q) begin
            ack_ph_q <= 1'b0; ack_drv_q <= 1'b0; bit_cnt_q <= '0;
            if (st_q == I_RSTART || st_q == I_RDATA) begin
              st_q <= I_RDATA;
              tx_q <= rd_data_i;
            end
          end else if (bit_cnt_q == 4'd8) begin
            ack_ph_q <= 1'b1;
            unique case (st_q)
              I_ADDR: begin
                if (sh_q[7:1] == dev_addr_i) begin
                  ack_drv_q <= 1'b1;
                  st_q      <= sh_q[0] ? I_RSTART : I_PTR;
                end else st_q <= I_IDLE;
              end
              I_PTR: begin
                ack_drv_q <= 1'b1; st_q <= I_WDATA;
                req_o.ptr_we <= 1'b1; req_o.data <= sh_q;
              end
              I_WDATA: begin
                ack_drv_q <= 1'b1;
                req_o.dat_we <= 1'b1; req_o.data <= sh_q;
              end
              default: ;
            endcase
          end else if (st_q == I_RDATA) begin
            tx_q <= {tx_q[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o = ack_drv_q | (st_q == I_RDATA && !ack_ph_q && !tx_q[DW-1]);

  p_ack_in_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_drv_q |-> ack_ph_q);
  p_idle_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == I_IDLE) |-> !sda_oe_o);
  p_nack_foreign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_ev && !stop_ev && scl_fall && !ack_ph_q && bit_cnt_q == 4'd8
     && st_q == I_ADDR && sh_q[7:1] != dev_addr_i) |=> !sda_oe_o);
endmodule

// File: rtl/cp_spi_fsm.sv
module cp_spi_fsm import cp_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       csn_i,
  input  logic [6:0] chip_addr_i,
  output cp_req_t    req_o
);
  logic          sck_q, dead_q;
  logic [2:0]    bit_cnt_q;
  logic [1:0]    byte_idx_q;
  logic [DW-1:0] sh_q, sh_nxt;

  assign sh_nxt = {sh_q[DW-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b1; dead_q <= 1'b0; bit_cnt_q <= '0; byte_idx_q <= '0;
      sh_q <= '0; req_o <= '0;
    end else begin
      sck_q <= sck_i;
      req_o <= '0;
      if (!en_i || csn_i) begin
        bit_cnt_q <= '0; byte_idx_q <= '0; dead_q <= 1'b0;
      end else if (sck_i && !sck_q) begin
        sh_q      <= sh_nxt;
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) begin
          if (byte_idx_q != 2'd2) byte_idx_q <= byte_idx_q + 1'b1;
          unique case (byte_idx_q)
            2'd0:    dead_q <= (sh_nxt != {chip_addr_i, 1'b0});
            2'd1:    begin req_o.ptr_we <= !dead_q; req_o.data <= sh_nxt; end
            default: begin req_o.dat_we <= !dead_q; req_o.data <= sh_nxt; end
          endcase
        end
      end
    end
  end

  p_dead_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_q && $past(dead_q)) |-> !(req_o.ptr_we || req_o.dat_we));
  p_no_read_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o.rd_adv);
endmodule

// File: rtl/dual_ctrl_port.sv
module dual_ctrl_port import cp_pkg::*; #(
  parameter int         NUM_REGS    = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b001000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic                   sclk_i,
  input  logic                   sdat_i,
  input  logic                   sel_i,
  output logic                   sdat_oe_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic          mode_q, mode_vld_q;
  logic          sclk_s, sdat_s, sel_s;
  logic          i2c_oe;
  cp_req_t       i2c_req, spi_req, req;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0; mode_vld_q <= 1'b0;
    end else if (!mode_vld_q) begin
      mode_q <= mode_i; mode_vld_q <= 1'b1;
    end
  end

  cp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, sdat_i, sel_i}), .q_o({sclk_s, sdat_s, sel_s})
  );

  cp_i2c_fsm u_i2c (
    .clk_i, .rst_ni, .en_i(mode_vld_q && !mode_q), .scl_i(sclk_s), .sda_i(sdat_s),
    .dev_addr_i({ADDR_HI, sel_s}), .rd_data_i(rd_data), .req_o(i2c_req), .sda_oe_o(i2c_oe)
  );

  cp_spi_fsm u_spi (
    .clk_i, .rst_ni, .en_i(mode_vld_q && mode_q), .sck_i(sclk_s), .sdi_i(sdat_s),
    .csn_i(sel_s), .chip_addr_i({ADDR_HI, 1'b0}), .req_o(spi_req)
  );

  assign req       = mode_q ? spi_req : i2c_req;
  assign sdat_oe_o = i2c_oe && !mode_q;

  cp_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i, .rst_ni, .req_i(req), .rd_data_o(rd_data), .regs_o
  );

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_vld_q |=> ($stable(mode_q) && mode_vld_q));
  p_spi_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !sdat_oe_o);
endmodule

// File: tb/dual_ctrl_port_tb_top.sv
module dual_ctrl_port_tb_top;
  localparam int N = 5;
  localparam int Q = 5;

  logic clk = 0, rst_n = 0, mode = 0, m_scl = 1, m_sda = 1, m_sel = 1;
  logic         oe;
  logic [N*8-1:0] regs;
  wire line = m_sda & ~oe;

  always #10 clk = ~clk;

  dual_ctrl_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sclk_i(m_scl), .sdat_i(line),
    .sel_i(m_sel), .sdat_oe_o(oe), .regs_o(regs)
  );

  int nvec = 0, nfail = 0, cyc = 0, last_chg = 0;
  int mregs[N];
  int mptr = 0;
  bit mincr = 0, cmp_on = 0, spi_ph = 0;
  string cur_req = "R10";

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h @cyc %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic void model_reset();
    foreach (mregs[i]) mregs[i] = 0;
    mptr = 0; mincr = 0; last_chg = cyc;
  endfunction

  // kind 1: pointer byte, kind 2: data byte
  function automatic void model_apply(int kind, logic [7:0] b);
    if (kind == 1) begin mincr = b[7]; mptr = int'(b[6:0]); end
    else if (kind == 2) begin
      if (mptr < N) mregs[mptr] = int'(b);
      if (mincr) mptr = (mptr + 1) % 128;
    end
    last_chg = cyc;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_on && rst_n && (cyc - last_chg) > 8) begin
      for (int i = 0; i < N; i++)
        chk(regs[i*8 +: 8] == mregs[i][7:0], cur_req, int'(regs[i*8 +: 8]), mregs[i]);
      if (spi_ph) chk(!oe, "R9 oe", int'(oe), 0);
    end
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic i2c_start(); m_sda = 0; w(Q); m_scl = 0; w(Q); endtask
  task automatic i2c_stop(); m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q); endtask

  task automatic i2c_byte(logic [7:0] b, int kind, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); m_scl = 1; w(2*Q); m_scl = 0;
      if (i == 0) model_apply(kind, b);
      w(Q);
    end
    m_sda = 1; w(Q); m_scl = 1; w(Q); ack = line; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic i2c_wr(logic [7:0] b, int kind, bit exp_ack, string tag);
    logic a;
    i2c_byte(b, kind, a);
    chk(a == !exp_ack, tag, int'(a), int'(!exp_ack));
  endtask

  task automatic i2c_rd(bit nack, string tag);
    logic [7:0] v;
    int exp;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_scl = 1; w(Q); v[i] = line; w(Q); m_scl = 0;
    end
    exp = (mptr < N) ? mregs[mptr] : 0;
    if (mincr) mptr = (mptr + 1) % 128;
    chk(v == exp[7:0], tag, int'(v), exp);
    w(Q); m_sda = nack; w(Q); m_scl = 1; w(2*Q); m_scl = 0; w(Q); m_sda = 1;
  endtask

  task automatic spi_byte(logic [7:0] b, int kind);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); m_scl = 1;
      if (i == 0) model_apply(kind, b);
      w(Q); m_scl = 0;
    end
    w(Q);
  endtask

  task automatic do_reset(bit md);
    rst_n = 0; mode = md; m_scl = md ? 0 : 1; m_sda = 1; m_sel = 1;
    w(4); model_reset(); rst_n = 1; w(4);
  endtask

  initial begin
    // ---------------- two-wire phase
    do_reset(0);
    chk(regs == '0, "R10 regs", int'(regs[31:0]), 0);
    chk(!oe, "R10 oe", int'(oe), 0);
    cmp_on = 1;
    mode = 1;  // R1: late change ignored
    cur_req = "R5";
    i2c_start(); i2c_wr(8'h22, 0, 1, "R1 R2 R3 addr ack");
    i2c_wr(8'h80, 1, 1, "R3 ptr ack");
    i2c_wr(8'hA1, 2, 1, "R5 ack"); i2c_wr(8'hB2, 2, 1, "R5 ack"); i2c_wr(8'hC3, 2, 1, "R5 ack");
    i2c_stop();
    cur_req = "R4";
    i2c_start(); i2c_wr(8'h22, 0, 1, "R3");
    i2c_wr(8'h03, 1, 1, "R4 ptr ack");
    i2c_wr(8'h11, 2, 1, "R4"); i2c_wr(8'h3C, 2, 1, "R4");
    i2c_stop();
    cur_req = "R6";
    i2c_start(); i2c_wr(8'h22, 0, 1, "R3");
    i2c_wr(8'h84, 1, 1, "R6");
    i2c_wr(8'h44, 2, 1, "R6"); i2c_wr(8'h55, 2, 1, "R6"); i2c_wr(8'h66, 2, 1, "R6");
    i2c_stop();
    cur_req = "R2";
    i2c_start(); i2c_wr(8'h20, 0, 0, "R2 foreign nack");
    i2c_wr(8'h80, 0, 0, "R2 ignored"); i2c_wr(8'h99, 0, 0, "R2 ignored");
    i2c_stop();
    cur_req = "R7";
    i2c_start(); i2c_wr(8'h22, 0, 1, "R3"); i2c_wr(8'h81, 1, 1, "R7 ptr"); i2c_stop();
    i2c_start(); i2c_wr(8'h23, 0, 1, "R7 read addr ack");
    i2c_rd(0, "R7 rd1"); i2c_rd(0, "R7 rd2"); i2c_rd(0, "R7 rd3");
    i2c_rd(0, "R7 rd4"); i2c_rd(1, "R7 rd oob");
    i2c_stop();
    chk(!oe, "R7 released after NACK", int'(oe), 0);
    i2c_start(); i2c_wr(8'h22, 0, 1, "R3"); i2c_wr(8'h02, 1, 1, "R7 ptr"); i2c_stop();
    i2c_start(); i2c_wr(8'h23, 0, 1, "R7");
    i2c_rd(0, "R7 hold1"); i2c_rd(1, "R7 hold2");
    i2c_stop();
    // ---------------- three-wire phase
    cmp_on = 0;
    do_reset(1);
    chk(regs == '0, "R10 regs spi", int'(regs[31:0]), 0);
    cmp_on = 1; spi_ph = 1;
    mode = 0;  // R1: late change ignored
    cur_req = "R8";
    m_sel = 0; w(Q);
    spi_byte(8'h20, 0); spi_byte(8'h80, 1); spi_byte(8'h5A, 2); spi_byte(8'hA5, 2);
    m_sel = 1; w(2*Q);
    cur_req = "R9";
    m_sel = 0; w(Q);
    spi_byte(8'h21, 0); spi_byte(8'h80, 0); spi_byte(8'hFF, 0);
    m_sel = 1; w(2*Q);
    m_sel = 0; w(Q);
    spi_byte(8'h22, 0); spi_byte(8'h81, 0); spi_byte(8'hEE, 0);
    m_sel = 1; w(2*Q);
    cur_req = "R4 R8";
    m_sel = 0; w(Q);
    spi_byte(8'h20, 0); spi_byte(8'h04, 1); spi_byte(8'h77, 2); spi_byte(8'h88, 2);
    m_sel = 1; w(20);
    chk(regs[39:32] == 8'h88, "R8 R4 final", int'(regs[39:32]), 'h88);
    chk(regs[7:0] == 8'h5A, "R8 reg0", int'(regs[7:0]), 'h5A);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule